// File: doc/BRIEF.md
# Physical Register Rename Unit

This block renames registers for an out-of-order core in which every value, speculative or committed, lives in one unified physical register file. No architectural register file exists, and the reorder buffer carries no result field. The unit holds three pieces of state. The first is a speculative map from each architectural register to a physical register, advanced at dispatch. The second is a retirement map holding the committed view, advanced at commit. The third is a free list of physical registers that may be allocated.

At dispatch the unit reads the physical tags of two source registers from the speculative map. If the instruction writes a register, the unit allocates the lowest-numbered free physical register and points the speculative map at it. At commit the reorder buffer supplies the architectural destination and the physical tag that was allocated for it. The retirement map takes that mapping, and the physical register the retirement map held before the update goes back to the free list. On a mispredict or squash the speculative map is copied from the retirement map. The free list is then rebuilt as every physical register that the retirement map does not reference.

Top module: `rename_core`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps. Physical registers 8 to 31 are free, and the first allocation returns tag 8.
- R2: `physSrcA` and `physSrcB` show the speculative mapping of `dispSrcA` and `dispSrcB` combinationally. They do not yet reflect a destination written by the same cycle's dispatch. A dispatch in a later cycle sees the new mapping.
- R3: A dispatch with `dispHasDst`=1 and a nonzero `dispDst` receives the lowest-numbered free physical register on `physDst`. That register leaves the free list. A dispatch with `dispHasDst`=0, or with `dispDst`=0, allocates nothing and leaves the speculative map unchanged, so architectural register 0 always reads physical register 0.
- R4: `dispReady` is low when a destination is requested and the free list is empty. A dispatch that needs no destination sees `dispReady` high regardless of the free list.
- R5: A commit with `cmtHasDst`=1 and a nonzero `cmtArch` writes `cmtPhys` into the retirement map. It returns the register previously held there to the free list. That register can be allocated from the next cycle onward, not by a dispatch in the same cycle.
- R6: A commit with `cmtHasDst`=0, or with `cmtArch`=0, changes neither the retirement map nor the free list.
- R7: When `recover` is high, the speculative map and the free list are rebuilt at the next edge from the retirement map, including any commit in the same cycle. `dispReady` is low in that cycle and that cycle's dispatch has no effect.
- R8: A physical register that is handed out is never one that the speculative map currently references, and two allocations in consecutive cycles never return the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispHasDst | input | 1 | Dispatched instruction writes a register |
| dispSrcA | input | 3 | First source architectural register |
| dispSrcB | input | 3 | Second source architectural register |
| dispDst | input | 3 | Destination architectural register |
| dispReady | output | 1 | Dispatch can be accepted this cycle |
| physSrcA | output | 5 | Physical tag of first source |
| physSrcB | output | 5 | Physical tag of second source |
| physDst | output | 5 | Physical tag allocated for the destination |
| cmtValid | input | 1 | Commit of the oldest instruction |
| cmtHasDst | input | 1 | Committing instruction writes a register |
| cmtArch | input | 3 | Committing destination architectural register |
| cmtPhys | input | 5 | Physical tag allocated to the committing instruction |
| recover | input | 1 | Mispredict or squash: restore from the retirement map |

## Verification
Some behaviours are checked by the assertions on every cycle. These are: forwarding of a new destination mapping to the next cycle's source read, register 0 staying pinned to physical register 0, the stall during recovery, the freshly allocated tag differing from a live source mapping, and allocations in consecutive cycles never repeating a tag. Other behaviours can be shown only by the bench's scenarios, because they depend on hidden state that surfaces later through allocation order and source reads. These are: draining the free list to a stall, the one-cycle delay before a released register is reused, commits that must be ignored, and the exact rebuild of both the map and the free list after recovery, including a commit in the same cycle.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 32;

  // strobes from control into the datapath
  typedef struct packed {
    logic allocWr;   // take a free register and remap the destination
    logic retireWr;  // update the retirement map and release the displaced tag
    logic restore;   // copy retirement state into speculative state
  } renStrobe_t;
endpackage

// File: rtl/rename_pick.sv
module rename_pick #(
  parameter int NumPhys = 32,
  localparam int PhysW = $clog2(NumPhys)
) (
  input  logic [NumPhys-1:0] freeVec,
  output logic [PhysW-1:0]   pick,
  output logic               anyFree
);
  logic [NumPhys-1:0] grant;

  // one-hot grant of the lowest set bit
  for (genvar i = 0; i < NumPhys; i++) begin : g_grant
    if (i == 0) begin : g_first
      assign grant[i] = freeVec[i];
    end else begin : g_rest
      assign grant[i] = freeVec[i] & ~(|freeVec[i-1:0]);
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NumPhys; i++) begin
      if (grant[i]) pick = pick | PhysW'(i);
    end
  end

  assign anyFree = |freeVec;
endmodule

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int NumArch = 8,
  localparam int ArchW = $clog2(NumArch)
) (
  input  logic             dispValid,
  input  logic             dispHasDst,
  input  logic [ArchW-1:0] dispDst,
  input  logic             cmtValid,
  input  logic             cmtHasDst,
  input  logic [ArchW-1:0] cmtArch,
  input  logic             recover,
  input  logic             anyFree,
  output logic             dispReady,
  output renStrobe_t       strobe
);
  logic needDst;

  // register 0 is never renamed
  assign needDst   = dispHasDst && (dispDst != '0);
  assign dispReady = !recover && (anyFree || !needDst);

  always_comb begin
    strobe          = '0;
    strobe.allocWr  = dispValid && dispReady && needDst;
    strobe.retireWr = cmtValid && cmtHasDst && (cmtArch != '0);
    strobe.restore  = recover;
  end
endmodule

// File: rtl/rename_dp.sv
module rename_dp
  import rename_pkg::*;
#(
  parameter int NumArch = 8,
  parameter int NumPhys = 32,
  localparam int ArchW = $clog2(NumArch),
  localparam int PhysW = $clog2(NumPhys)
) (
  input  logic             clk,
  input  logic             rstN,
  input  renStrobe_t       strobe,
  input  logic [ArchW-1:0] dispSrcA,
  input  logic [ArchW-1:0] dispSrcB,
  input  logic [ArchW-1:0] dispDst,
  input  logic [ArchW-1:0] cmtArch,
  input  logic [PhysW-1:0] cmtPhys,
  output logic [PhysW-1:0] physSrcA,
  output logic [PhysW-1:0] physSrcB,
  output logic [PhysW-1:0] physDst,
  output logic             anyFree
);
  logic [PhysW-1:0]   specMap [NumArch];
  logic [PhysW-1:0]   retMap  [NumArch];
  logic [PhysW-1:0]   retNext [NumArch];
  logic [PhysW-1:0]   specNext[NumArch];
  logic [NumPhys-1:0] freeVec, freeNext;
  logic [NumPhys-1:0] allocMask, relMask, refMask;
  logic [PhysW-1:0]   pickTag;

  rename_pick #(.NumPhys(NumPhys)) u_pick (
    .freeVec(freeVec),
    .pick   (pickTag),
    .anyFree(anyFree)
  );

  assign physSrcA = specMap[dispSrcA];
  assign physSrcB = specMap[dispSrcB];
  assign physDst  = pickTag;

  // committed view after this cycle's commit, used for restore
  always_comb begin
    for (int a = 0; a < NumArch; a++) retNext[a] = retMap[a];
    relMask = '0;
    if (strobe.retireWr) begin
      retNext[cmtArch]         = cmtPhys;
      relMask[retMap[cmtArch]] = 1'b1;
    end
  end

  always_comb begin
    refMask = '0;
    for (int a = 0; a < NumArch; a++) refMask[retNext[a]] = 1'b1;
  end

  always_comb begin
    allocMask = '0;
    for (int a = 0; a < NumArch; a++) specNext[a] = specMap[a];
    if (strobe.allocWr) begin
      allocMask[pickTag] = 1'b1;
      specNext[dispDst]  = pickTag;
    end
    if (strobe.restore) begin
      for (int a = 0; a < NumArch; a++) specNext[a] = retNext[a];
      freeNext = ~refMask;
    end else begin
      freeNext = (freeVec & ~allocMask) | relMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NumArch; a++) begin
        specMap[a] <= PhysW'(a);
        retMap[a]  <= PhysW'(a);
      end
      for (int p = 0; p < NumPhys; p++) freeVec[p] <= (p >= NumArch);
    end else begin
      for (int a = 0; a < NumArch; a++) begin
        specMap[a] <= specNext[a];
        retMap[a]  <= retNext[a];
      end
      freeVec <= freeNext;
    end
  end
endmodule

// File: rtl/rename_core.sv
module rename_core
  import rename_pkg::*;
#(
  parameter int NumArch = ARCH_REGS,
  parameter int NumPhys = PHYS_REGS,
  localparam int ArchW = $clog2(NumArch),
  localparam int PhysW = $clog2(NumPhys)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             dispHasDst,
  input  logic [ArchW-1:0] dispSrcA,
  input  logic [ArchW-1:0] dispSrcB,
  input  logic [ArchW-1:0] dispDst,
  output logic             dispReady,
  output logic [PhysW-1:0] physSrcA,
  output logic [PhysW-1:0] physSrcB,
  output logic [PhysW-1:0] physDst,
  input  logic             cmtValid,
  input  logic             cmtHasDst,
  input  logic [ArchW-1:0] cmtArch,
  input  logic [PhysW-1:0] cmtPhys,
  input  logic             recover
);
  renStrobe_t strobe;
  logic       anyFree;

  rename_ctrl #(.NumArch(NumArch)) u_ctrl (
    .dispValid (dispValid),
    .dispHasDst(dispHasDst),
    .dispDst   (dispDst),
    .cmtValid  (cmtValid),
    .cmtHasDst (cmtHasDst),
    .cmtArch   (cmtArch),
    .recover   (recover),
    .anyFree   (anyFree),
    .dispReady (dispReady),
    .strobe    (strobe)
  );

  rename_dp #(.NumArch(NumArch), .NumPhys(NumPhys)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dispSrcA(dispSrcA),
    .dispSrcB(dispSrcB),
    .dispDst (dispDst),
    .cmtArch (cmtArch),
    .cmtPhys (cmtPhys),
    .physSrcA(physSrcA),
    .physSrcB(physSrcB),
    .physDst (physDst),
    .anyFree (anyFree)
  );
endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
  parameter int ArchW = 3,
  parameter int PhysW = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             dispHasDst,
  input logic [ArchW-1:0] dispSrcA,
  input logic [ArchW-1:0] dispDst,
  input logic             dispReady,
  input logic [PhysW-1:0] physSrcA,
  input logic [PhysW-1:0] physDst,
  input logic             recover
);
  logic pastOk;
  logic allocNow;

  assign allocNow = dispValid && dispReady && dispHasDst && (dispDst != '0);

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R2: the mapping written at dispatch is seen by the next cycle's source read
  p_src_forward_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(allocNow) && dispSrcA == $past(dispDst)) |-> physSrcA == $past(physDst));

  // R3: architectural register 0 stays on physical register 0
  p_zero_pinned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dispSrcA == '0) |-> physSrcA == '0);

  // R7: no dispatch is accepted during recovery
  p_recover_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    recover |-> !dispReady);

  // R8: consecutive allocations hand out different tags
  p_alloc_distinct_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && allocNow && $past(allocNow)) |-> physDst != $past(physDst));

  // R8: the tag handed out is not a live speculative mapping
  p_dst_not_live_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dispReady && dispHasDst && dispDst != '0 && !recover) |-> physDst != physSrcA);
endmodule

bind rename_core rename_checker #(.ArchW(ArchW), .PhysW(PhysW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dispValid (dispValid),
  .dispHasDst(dispHasDst),
  .dispSrcA  (dispSrcA),
  .dispDst   (dispDst),
  .dispReady (dispReady),
  .physSrcA  (physSrcA),
  .physDst   (physDst),
  .recover   (recover)
);

// File: tb/tb_rename_core.sv
module tb_rename_core;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NA = 8;
  localparam int NP = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dispValid = 1'b0, dispHasDst = 1'b0;
  logic [2:0] dispSrcA = '0, dispSrcB = '0, dispDst = '0;
  logic       dispReady;
  logic [4:0] physSrcA, physSrcB, physDst;
  logic       cmtValid = 1'b0, cmtHasDst = 1'b0;
  logic [2:0] cmtArch = '0;
  logic [4:0] cmtPhys = '0;
  logic       recover = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rename_core dut (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispHasDst(dispHasDst),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .dispDst(dispDst),
    .dispReady(dispReady), .physSrcA(physSrcA), .physSrcB(physSrcB), .physDst(physDst),
    .cmtValid(cmtValid), .cmtHasDst(cmtHasDst), .cmtArch(cmtArch), .cmtPhys(cmtPhys),
    .recover(recover)
  );

  typedef struct packed {
    logic       ckDst;
    logic       expReady;
    logic [4:0] expA;
    logic [4:0] expB;
    logic [4:0] expDst;
  } expItem_t;

  expItem_t expQ[$];
  string    reqQ[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state built from the requirements
  int mSpec[NA];
  int mRet[NA];
  bit mFree[NP];
  int robArch[$];
  int robPhys[$];
  int robHas[$];

  function automatic int countFree();
    int n = 0;
    for (int p = 0; p < NP; p++) n += mFree[p];
    return n;
  endfunction

  function automatic int lowestFree();
    for (int p = 0; p < NP; p++) if (mFree[p]) return p;
    return 0;
  endfunction

  task automatic modelReset();
    for (int a = 0; a < NA; a++) begin mSpec[a] = a; mRet[a] = a; end
    for (int p = 0; p < NP; p++) mFree[p] = (p >= NA);
    robArch.delete(); robPhys.delete(); robHas.delete();
  endtask

  // cmMode: 0 none, 1 commit oldest, 2 commit to register 0, 3 commit without destination
  task automatic step(string req, bit dv, bit dh, int sa, int sb, int dd, int cmMode, bit rc);
    expItem_t e;
    bit need, fire, cv, ch;
    int ca, cp, low;
    @(negedge clk);
    cv = 0; ch = 0; ca = 0; cp = 0;
    if (cmMode == 1 && robArch.size() > 0) begin
      cv = 1; ca = robArch[0]; cp = robPhys[0]; ch = (robHas[0] != 0);
    end else if (cmMode == 2) begin
      cv = 1; ch = 1; ca = 0; cp = 31;
    end else if (cmMode == 3) begin
      cv = 1; ch = 0; ca = 2; cp = 31;
    end
    dispValid = dv; dispHasDst = dh;
    dispSrcA = 3'(sa); dispSrcB = 3'(sb); dispDst = 3'(dd);
    cmtValid = cv; cmtHasDst = ch; cmtArch = 3'(ca); cmtPhys = 5'(cp);
    recover = rc;

    need = dh && (dd != 0);
    low = lowestFree();
    e.expReady = !rc && (countFree() > 0 || !need);
    e.expA = 5'(mSpec[sa]);
    e.expB = 5'(mSpec[sb]);
    e.ckDst = need && e.expReady;
    e.expDst = 5'(low);
    expQ.push_back(e);
    reqQ.push_back(req);

    fire = dv && e.expReady;
    if (fire && need) begin
      mSpec[dd] = low;
      mFree[low] = 0;
    end
    if (fire) begin
      robArch.push_back(dd); robPhys.push_back(low); robHas.push_back(need ? 1 : 0);
    end
    if (cmMode == 1 && cv) begin
      void'(robArch.pop_front()); void'(robPhys.pop_front()); void'(robHas.pop_front());
      if (ch && ca != 0) begin
        mFree[mRet[ca]] = 1;
        mRet[ca] = cp;
      end
    end
    if (rc) begin
      for (int a = 0; a < NA; a++) mSpec[a] = mRet[a];
      for (int p = 0; p < NP; p++) mFree[p] = 1;
      for (int a = 0; a < NA; a++) mFree[mRet[a]] = 0;
      robArch.delete(); robPhys.delete(); robHas.delete();
    end
    @(posedge clk);
  endtask

  // monitor: compares just before each rising edge
  initial begin
    expItem_t e;
    string r;
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        r = reqQ.pop_front();
        checks++;
        if (dispReady !== e.expReady) begin
          errors++;
          $display("FAIL %s dispReady actual %0b expected %0b", r, dispReady, e.expReady);
        end
        checks++;
        if (physSrcA !== e.expA || physSrcB !== e.expB) begin
          errors++;
          $display("FAIL %s sources actual %0d/%0d expected %0d/%0d", r, physSrcA, physSrcB, e.expA, e.expB);
        end
        if (e.ckDst) begin
          checks++;
          if (physDst !== e.expDst) begin
            errors++;
            $display("FAIL %s physDst actual %0d expected %0d", r, physDst, e.expDst);
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset mapping is identity, first tag is 8
    for (int i = 0; i < NA; i++) step("R1", 0, 0, i, NA - 1 - i, 0, 0, 0);
    step("R1", 1, 1, 2, 3, 1, 0, 0);           // R1=R2*R3 -> tag 8, sources 2 and 3
    // R2: next dispatch sees the new mapping of register 1
    step("R2", 1, 1, 1, 3, 3, 0, 0);
    step("R2", 1, 1, 3, 1, 4, 0, 0);
    // R3: register 0 and no-destination dispatches allocate nothing
    step("R3", 1, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 4, 0, 5, 0, 0);
    step("R3", 1, 1, 5, 0, 5, 0, 0);
    // R6: ignored commits release nothing, so tag 0 never appears
    step("R6", 0, 0, 0, 0, 0, 2, 0);
    step("R6", 0, 0, 0, 0, 0, 3, 0);
    step("R6", 1, 1, 0, 2, 6, 0, 0);
    // R4: drain the free list
    while (countFree() > 0) step("R4", 1, 1, 2, 6, 2, 0, 0);
    step("R4", 1, 1, 2, 6, 7, 0, 0);            // stall expected
    step("R4", 1, 0, 1, 2, 7, 0, 0);            // no destination: ready
    // R5: freed register not usable in the commit cycle, usable after
    step("R5", 1, 1, 1, 2, 7, 1, 0);
    step("R5", 1, 1, 7, 1, 7, 0, 0);
    step("R5", 0, 0, 3, 4, 0, 1, 0);
    step("R5", 0, 0, 5, 6, 0, 1, 0);
    step("R5", 1, 1, 5, 3, 3, 1, 0);
    step("R5", 1, 1, 3, 7, 6, 0, 0);
    // R7: recovery with a commit in the same cycle and a blocked dispatch
    step("R7", 1, 1, 1, 2, 3, 1, 1);
    for (int i = 0; i < NA; i++) step("R7", 0, 0, i, i, 0, 0, 0);
    step("R7", 1, 1, 3, 4, 3, 0, 0);
    step("R7", 1, 1, 3, 1, 1, 0, 0);
    // R8: mixed traffic; allocated tags never collide with live mappings
    for (int i = 0; i < 24; i++) step("R8", 1, 1, (i * 3) % NA, (i * 5 + 1) % NA, (i % 7) + 1, (i % 3 == 0) ? 0 : 1, 0);
    step("R7", 0, 0, 1, 2, 0, 0, 1);
    for (int i = 0; i < NA; i++) step("R7", 1, 1, i, (i + 1) % NA, i, 0, 0);

    @(negedge clk);
    dispValid = 0; cmtValid = 0; recover = 0;
    while (expQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule